// File: doc/BRIEF.md
# Masked Burst Address Counter

This block produces the address for one port of a synchronous memory during burst transfers. An external start address can be loaded into the counter. The same load also stores that address in a mirror register. A mask register chooses which address bits take part in counting. Bits outside the mask keep their value while the burst runs. The counted bits advance by one on each enabled clock. When they are already all ones, the next increment wraps. A wrap select input picks what the wrap does: it either clears the counted bits or reloads them from the mirror. An active-low interrupt shows that the counted bits are all ones.

Each clock the decoder picks exactly one operation. In order of priority they are:

- CLEAR: counter to zero and mask to all ones.
- LOAD_ADDR: counter and mirror take the address input.
- LOAD_MASK: mask takes the address input.
- RETRANSMIT: counter takes the mirror.
- INCREMENT: counted bits advance or wrap.
- HOLD: nothing changes.

Every operation returns to the decoder on the next clock, so the block moves between these states one cycle at a time. The asynchronous active-low reset leaves the counter and the mirror at zero and the mask at all ones.

Top module: `burst_addr_ctr`

## Requirements
- R1: After reset, addr_out is 0 and ctr_int_n is 1. The mask is all ones, so the first increment gives 1.
- R2: With ld_stb=1 and mask_sel=0, addr_out equals addr_in on the next clock. The mirror also takes addr_in.
- R3: With ld_stb=1 and mask_sel=1, the mask takes addr_in and addr_out holds its value. A mask bit of 1 means the bit counts.
- R4: With cnt_en=1 and the counted bits not all ones, the counted bits advance by one. The carry passes from each counted bit to the next counted bit above it. Uncounted bits hold.
- R5: With cnt_en=1, the counted bits all ones and wrap_sel=0, the counted bits become 0. Uncounted bits hold.
- R6: With cnt_en=1, the counted bits all ones and wrap_sel=1, the counted bits take the mirror's values at the same positions. Uncounted bits hold.
- R7: With rtx_req=1, addr_out equals the last loaded start address on the next clock.
- R8: With ctr_clr=1, addr_out becomes 0 and the mask becomes all ones.
- R9: When more than one control input is active, the winner follows the priority order CLEAR, then any load, then RETRANSMIT, then INCREMENT.
- R10: ctr_int_n is 0 exactly when every counted bit of addr_out is 1, and 1 otherwise.
- R11: With no control input active, addr_out and ctr_int_n hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_stb | input | 1 | Load strobe for the address or the mask |
| mask_sel | input | 1 | When 1, a load writes the mask |
| cnt_en | input | 1 | Count enable |
| ctr_clr | input | 1 | Counter clear |
| rtx_req | input | 1 | Retransmit: restore the counter from the mirror |
| wrap_sel | input | 1 | Wrap action: 0 clears, 1 reloads from the mirror |
| addr_in | input | AW | External address or mask value |
| addr_out | output | AW | Current counter address |
| ctr_int_n | output | 1 | Terminal-count interrupt, active low |

## Verification
The increment path is tried with three masks:
- A two-bit low mask, so wrapping happens often. Both wrap_sel values are used there, which separates clearing the counted bits from reloading them out of the mirror.
- The full-width mask, which shows that the terminal flag and the wrap use every bit.
- A mask covering only the upper bits. This proves that carries skip the uncounted bits and that low bits hold.

Stacked control inputs separate the four priority levels. A reset in the middle of a burst checks that the mask returns to all ones.

// File: rtl/bac_pkg.sv
package bac_pkg;
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_CLR   = 3'd1,
        OP_LDA   = 3'd2,
        OP_LDM   = 3'd3,
        OP_RTX   = 3'd4,
        OP_INC   = 3'd5
    } bac_op_e;
endpackage

// File: rtl/bac_op_decode.sv
module bac_op_decode
    import bac_pkg::*;
(
    input  logic    ctr_clr,
    input  logic    ld_stb,
    input  logic    mask_sel,
    input  logic    rtx_req,
    input  logic    cnt_en,
    output bac_op_e op
);
    always_comb begin
        unique casez ({ctr_clr, ld_stb, mask_sel, rtx_req, cnt_en})
            5'b1????: op = OP_CLR;
            5'b011??: op = OP_LDM;
            5'b010??: op = OP_LDA;
            5'b00?1?: op = OP_RTX;
            5'b00?01: op = OP_INC;
            default:  op = OP_HOLD;
        endcase
    end
endmodule

// File: rtl/bac_cfg_regs.sv
module bac_cfg_regs
    import bac_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bac_op_e       op,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] msk,
    output logic [AW-1:0] mir
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msk <= '1;
            mir <= '0;
        end else begin
            unique case (op)
                OP_CLR:  msk <= '1;
                OP_LDM:  msk <= addr_in;
                OP_LDA:  mir <= addr_in;
                default: ;
            endcase
        end
    end

    assert_mask_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_CLR && op != OP_LDM) |=> $stable(msk));
    assert_mask_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLR) |=> (msk == {AW{1'b1}}));
    assert_mirror_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LDA) |=> (mir == $past(addr_in)));
endmodule

// File: rtl/bac_count_core.sv
module bac_count_core
    import bac_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bac_op_e       op,
    input  logic          wrap_sel,
    input  logic [AW-1:0] addr_in,
    input  logic [AW-1:0] msk,
    input  logic [AW-1:0] mir,
    output logic [AW-1:0] cnt,
    output logic          term
);
    logic [AW-1:0] cnt_nxt;
    logic [AW-1:0] hold_bits;
    logic [AW-1:0] step_bits;

    assign term      = &(cnt | ~msk);
    assign hold_bits = cnt & ~msk;
    assign step_bits = ((cnt | ~msk) + {{(AW-1){1'b0}}, 1'b1}) & msk;

    always_comb begin
        unique case (op)
            OP_CLR:  cnt_nxt = '0;
            OP_LDA:  cnt_nxt = addr_in;
            OP_RTX:  cnt_nxt = mir;
            OP_INC: begin
                if (!term)
                    cnt_nxt = hold_bits | step_bits;
                else if (wrap_sel)
                    cnt_nxt = hold_bits | (mir & msk);
                else
                    cnt_nxt = hold_bits;
            end
            default: cnt_nxt = cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD || op == OP_LDM) |=> $stable(cnt));
    assert_high_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INC) |=> ((cnt & ~msk) == $past(cnt & ~msk)));
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LDA) |=> (cnt == $past(addr_in)));
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLR) |=> (cnt == '0));
    assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INC && term && !wrap_sel) |=> ((cnt & msk) == '0));
    assert_rtx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RTX) |=> (cnt == $past(mir)));
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
    import bac_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_stb,
    input  logic          mask_sel,
    input  logic          cnt_en,
    input  logic          ctr_clr,
    input  logic          rtx_req,
    input  logic          wrap_sel,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_out,
    output logic          ctr_int_n
);
    bac_op_e       op;
    logic [AW-1:0] msk;
    logic [AW-1:0] mir;
    logic          term;

    bac_op_decode u_dec (
        .ctr_clr (ctr_clr),
        .ld_stb  (ld_stb),
        .mask_sel(mask_sel),
        .rtx_req (rtx_req),
        .cnt_en  (cnt_en),
        .op      (op)
    );

    bac_cfg_regs #(.AW(AW)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .addr_in(addr_in),
        .msk    (msk),
        .mir    (mir)
    );

    bac_count_core #(.AW(AW)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .wrap_sel(wrap_sel),
        .addr_in (addr_in),
        .msk     (msk),
        .mir     (mir),
        .cnt     (addr_out),
        .term    (term)
    );

    assign ctr_int_n = ~term;

    assert_int_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctr_int_n) |-> ($past(op) != OP_CLR && $past(op) != OP_HOLD));
    assert_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_clr && ld_stb && !mask_sel) |=> (addr_out == '0));
endmodule

// File: tb/sim_burst_addr_ctr.sv
module sim_burst_addr_ctr;
    localparam int AW = 18;
    localparam int NV = 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_stb = 0, mask_sel = 0, cnt_en = 0, ctr_clr = 0, rtx_req = 0, wrap_sel = 0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic          ctr_int_n;
    int            checks = 0;
    int            errors = 0;
    bit            done = 0;

    always #10 clk = ~clk;

    burst_addr_ctr #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .mask_sel(mask_sel),
        .cnt_en(cnt_en), .ctr_clr(ctr_clr), .rtx_req(rtx_req), .wrap_sel(wrap_sel),
        .addr_in(addr_in), .addr_out(addr_out), .ctr_int_n(ctr_int_n)
    );

    // entry: tag[3:0], {clr,ld,msel,rtx,en,wrap}, addr_in, expected addr, expected int_n
    localparam logic [46:0] VEC [NV] = '{
        {4'd2,  6'b010000, 18'h00005, 18'h00005, 1'b1}, // R2 load
        {4'd3,  6'b011000, 18'h00003, 18'h00005, 1'b1}, // R3 mask load, addr holds
        {4'd4,  6'b000010, 18'h00000, 18'h00006, 1'b1}, // R4
        {4'd10, 6'b000010, 18'h00000, 18'h00007, 1'b0}, // R10 terminal
        {4'd5,  6'b000010, 18'h00000, 18'h00004, 1'b1}, // R5 wrap clear
        {4'd11, 6'b000000, 18'h3FFFF, 18'h00004, 1'b1}, // R11 hold
        {4'd4,  6'b000010, 18'h00000, 18'h00005, 1'b1}, // R4
        {4'd4,  6'b000011, 18'h00000, 18'h00006, 1'b1}, // R4
        {4'd10, 6'b000011, 18'h00000, 18'h00007, 1'b0}, // R10
        {4'd6,  6'b000011, 18'h00000, 18'h00005, 1'b1}, // R6 wrap reload
        {4'd2,  6'b010000, 18'h2ABCD, 18'h2ABCD, 1'b1}, // R2
        {4'd4,  6'b000010, 18'h00000, 18'h2ABCE, 1'b1}, // R4
        {4'd10, 6'b000010, 18'h00000, 18'h2ABCF, 1'b0}, // R10
        {4'd7,  6'b000100, 18'h00000, 18'h2ABCD, 1'b1}, // R7 retransmit
        {4'd4,  6'b000010, 18'h00000, 18'h2ABCE, 1'b1}, // R4
        {4'd9,  6'b000110, 18'h00000, 18'h2ABCD, 1'b1}, // R9 rtx over inc
        {4'd9,  6'b010110, 18'h00010, 18'h00010, 1'b1}, // R9 load over rtx
        {4'd8,  6'b110010, 18'h3FFFF, 18'h00000, 1'b1}, // R8 clear over load
        {4'd8,  6'b000010, 18'h00000, 18'h00001, 1'b1}, // R8 mask all ones
        {4'd3,  6'b011010, 18'h3FFF0, 18'h00001, 1'b1}, // R3 upper mask
        {4'd4,  6'b000010, 18'h00000, 18'h00011, 1'b1}  // R4 carry skips low bits
    };

    function automatic string tag(input int n);
        case (n)
            1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
            5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
            9: return "R9";  10: return "R10"; 11: return "R11";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string req, input logic [AW-1:0] ea, input logic ei);
        checks++;
        if (addr_out !== ea || ctr_int_n !== ei) begin
            errors++;
            $display("FAIL %s addr=%h int_n=%b expected addr=%h int_n=%b",
                     req, addr_out, ctr_int_n, ea, ei);
        end
    endtask

    task automatic step(input logic [5:0] c, input logic [AW-1:0] a);
        {ctr_clr, ld_stb, mask_sel, rtx_req, cnt_en, wrap_sel} = c;
        addr_in = a;
        @(negedge clk);
        {ctr_clr, ld_stb, mask_sel, rtx_req, cnt_en, wrap_sel} = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 18'h0, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][42:37], VEC[i][36:19]);
            check(tag(int'(VEC[i][46:43])), VEC[i][18:1], VEC[i][0]);
        end
        // full-width terminal and wrap
        step(6'b100000, '0);
        step(6'b010000, 18'h3FFFE);
        step(6'b000010, '0);
        check("R10", 18'h3FFFF, 1'b0);
        step(6'b000010, '0);
        check("R5", 18'h00000, 1'b1);
        step(6'b010000, 18'h3FFFF);
        check("R10", 18'h3FFFF, 1'b0);
        step(6'b000011, '0);
        check("R6", 18'h3FFFF, 1'b0);
        // reset during a burst with a narrow mask
        step(6'b011000, 18'h00001);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 18'h00000, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        step(6'b000010, '0);
        step(6'b000010, '0);
        check("R1", 18'h00002, 1'b1);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule